// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block decodes every bus cycle from a bus master into chip-select strobes for external memories and peripherals. There are twelve channels. Channel 0 is the boot channel, and channels 1 to 11 are the general selects G0 to G10. Each channel has three registers: a base word that sets the window start and size, an option word that sets the cycle qualifiers and the timing, and a two-bit pin-function code. Any number of windows may overlap. Every channel that matches pulls its pin low in the same cycle.

When a cycle hits a window, the block also closes the transfer. It drives a two-line data acknowledge that reports the port width, after a programmed number of wait cycles. During an interrupt-acknowledge cycle it can drive an autovector acknowledge instead. Pins that are not programmed as selects drive something else: G3 to G9 drive bits of a latched discrete output byte, G10 drives an auxiliary clock, and the remaining pins idle high.

After reset only the boot channel is live. It covers the first megabyte as a 16-bit port with 13 wait cycles, so code can be fetched before software has programmed anything.

Top module: `csel_unit`

The acknowledge sequencer has five states:
- IDLE waits for a hit.
- COUNT burns the wait cycles.
- ACK drives the data acknowledge.
- AUTO drives the autovector acknowledge.
- EXT waits for an external device to end the cycle.

Its transitions are:
- IDLE->COUNT on a hit with wait code 0..13.
- IDLE->ACK on a hit with code 14.
- IDLE->EXT on a hit with code 15.
- IDLE->AUTO on an autovectored interrupt acknowledge.
- COUNT->ACK when the count reaches zero.
- Any non-IDLE state returns to IDLE when the address strobe is high at a clock edge.

## Requirements
- R1: A channel whose pin code selects a chip-select drives its pin low exactly when the cycle address lies in its window. The window starts at base word bits [15:3] (address bits 23..11), rounded down to a multiple of the block size. Base word bits [2:0] pick the size: 0..7 give 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes.
- R2: All channels that hit in a cycle drive their pins low together, whatever their index.
- R3: The pin code sets what the pin drives. 2'b11 is a 16-bit select, 2'b10 an 8-bit select, 2'b01 a constant high, and 2'b00 the pin's alternate output. The alternate output is discrete bit k on G(3+k) for k = 0..6, the auxiliary clock on G10, and high on the boot pin and on G0 to G2.
- R4: Option bits [5:4] allow read cycles (bit 4) and write cycles (bit 5). Option bit 8 restricts the channel to word accesses. Option bit 9 must equal the interrupt-acknowledge input for the channel to hit.
- R5: Option bit 6 chooses the qualifying strobe: 0 means the address strobe, 1 means the data strobe. Without its strobe low, no channel asserts.
- R6: Option bits [3:0] hold the wait code. Samples are taken half a clock after the edges. With the strobe driven low half a clock before edge 0, codes 0..13 acknowledge after edge code+1, code 14 acknowledges after edge 0, and code 15 never acknowledges.
- R7: The data acknowledge is two active-low lines. 2'b00 reports a 16-bit port, 2'b10 an 8-bit port, and 2'b11 means idle. 2'b01 never occurs.
- R8: In an interrupt-acknowledge cycle whose acknowledging channel has option bit 7 set, the autovector output goes low after edge 0 and the data acknowledge stays idle.
- R9: Once the address strobe is high at a clock edge, both acknowledges are idle after that edge.
- R10: After reset, the boot channel covers 0x000000..0x0FFFFF as a 16-bit select with reads and writes on the address strobe and wait code 13. The general pins have code 2'b00 and options 0, and the discrete byte is all ones.
- R11: When several channels hit, the lowest-indexed one, with the boot channel lowest, sets the wait code, the port width and the autovector choice.
- R12: The register port writes on the write enable. The kind field selects the register: 0 base, 1 option (data[9:0]), 2 pin code (data[1:0]), 3 discrete byte (data[6:0], channel ignored). Channel numbers 12..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind selector |
| wr_chan | input | 4 | Channel index, 0 = boot |
| wr_data | input | 16 | Write data |
| addr | input | 24 | Bus cycle address |
| rnw | input | 1 | 1 = read cycle |
| word_acc | input | 1 | 1 = word access, 0 = byte |
| iack | input | 1 | Interrupt-acknowledge cycle |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| aux_clk | input | 1 | Clock routed to G10 in alternate mode |
| cs_pin_n | output | 12 | Pin outputs, bit 0 boot, bit k+1 = Gk |
| dsack_n | output | 2 | Data acknowledge with port width |
| avec_n | output | 1 | Autovector acknowledge, active low |

## Verification
The bench sweeps every size code at the first and last byte inside a window and at the bytes just outside it. A wrong mask would shift the boundary by a whole size step, and an unrounded base would miss the start. It walks all sixteen wait codes, where an off-by-one counter or a fast code treated as plain 14 shows up as a latency error, and the external code as an acknowledge that appears anyway. Overlapping windows catch a priority encoder that suppresses pins or takes the acknowledge timing from the wrong channel. The qualifier, strobe and writes to channels 12..15 cases catch selects that assert when they must not, or writes that alias onto the boot channel.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;

    localparam int MIN_SHIFT = 11;
    localparam int SIZE_W    = 3;
    localparam int FUNC_W    = 2;
    localparam int WAIT_W    = 4;

    typedef enum logic [1:0] {
        KIND_BASE = 2'd0,
        KIND_OPT  = 2'd1,
        KIND_FUNC = 2'd2,
        KIND_DISC = 2'd3
    } wr_kind_t;

    typedef enum logic [FUNC_W-1:0] {
        PIN_ALT  = 2'b00,
        PIN_OFF  = 2'b01,
        PIN_CS8  = 2'b10,
        PIN_CS16 = 2'b11
    } pin_func_t;

    typedef struct packed {
        logic              iack_sp;
        logic              word_only;
        logic              autovec;
        logic              ds_sync;
        logic [1:0]        dir;
        logic [WAIT_W-1:0] wait_code;
    } opt_t;

    typedef struct packed {
        logic       iack_sp;
        logic       word_only;
        logic       ds_sync;
        logic [1:0] dir;
    } qual_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_ACK,
        ST_AUTO,
        ST_EXT
    } ack_state_t;

    // number of low address bits ignored for a given size code
    function automatic int unsigned size_shift(input logic [SIZE_W-1:0] code);
        int unsigned c;
        c = int'(code);
        if (c == 0)
            return MIN_SHIFT;
        else if (c < 3)
            return c + 12;
        else
            return c + 13;
    endfunction

endpackage

// File: rtl/csel_regs.sv
`timescale 1ns/1ps
module csel_regs
    import csel_pkg::*;
#(
    parameter int NCH       = 12,
    parameter int DATA_W    = 16,
    parameter int CHAN_W    = 4,
    parameter int DISC_W    = 7,
    parameter int BOOT_WAIT = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_kind,
    input  logic [CHAN_W-1:0]            wr_chan,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NCH-1:0][DATA_W-1:0]   base_q,
    output opt_t [NCH-1:0]               opt_q,
    output logic [NCH-1:0][FUNC_W-1:0]   func_q,
    output logic [DISC_W-1:0]            disc_q
);

    localparam int OPT_W = $bits(opt_t);
    localparam logic [DATA_W-1:0] BOOT_BASE = DATA_W'(7);
    localparam opt_t BOOT_OPT = '{
        iack_sp:   1'b0,
        word_only: 1'b0,
        autovec:   1'b0,
        ds_sync:   1'b0,
        dir:       2'b11,
        wait_code: WAIT_W'(BOOT_WAIT)
    };

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                base_q[ch] <= (ch == 0) ? BOOT_BASE : '0;
                opt_q[ch]  <= (ch == 0) ? BOOT_OPT : '0;
                func_q[ch] <= (ch == 0) ? PIN_CS16 : PIN_ALT;
            end
            disc_q <= '1;
        end else if (wr_en) begin
            if (wr_kind == KIND_DISC) begin
                disc_q <= wr_data[DISC_W-1:0];
            end
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_chan == CHAN_W'(ch)) begin
                    unique case (wr_kind)
                        KIND_BASE: base_q[ch] <= wr_data;
                        KIND_OPT:  opt_q[ch]  <= opt_t'(wr_data[OPT_W-1:0]);
                        KIND_FUNC: func_q[ch] <= wr_data[FUNC_W-1:0];
                        default:   ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/csel_match.sv
`timescale 1ns/1ps
module csel_match
    import csel_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int ADDR_W = 24,
    parameter int BASE_W = 16
) (
    input  logic [NCH-1:0][BASE_W-1:0] base,
    input  qual_t [NCH-1:0]            qual,
    input  logic [NCH-1:0]             cs_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       rnw,
    input  logic                       word_acc,
    input  logic                       iack,
    input  logic                       as_n,
    input  logic                       ds_n,
    output logic [NCH-1:0]             hit
);

    localparam int FIELD_W = BASE_W - SIZE_W;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] start;
        logic              in_win;
        logic              dir_ok;
        logic              size_ok;
        logic              space_ok;
        logic              strobe_ok;

        assign mask      = {ADDR_W{1'b1}} << size_shift(base[i][SIZE_W-1:0]);
        assign start     = ADDR_W'({base[i][BASE_W-1:SIZE_W], {MIN_SHIFT{1'b0}}});
        assign in_win    = ((addr ^ start) & mask) == '0;
        assign dir_ok    = rnw ? qual[i].dir[0] : qual[i].dir[1];
        assign size_ok   = !qual[i].word_only || word_acc;
        assign space_ok  = qual[i].iack_sp == iack;
        assign strobe_ok = qual[i].ds_sync ? !ds_n : !as_n;
        assign hit[i]    = cs_en[i] && in_win && dir_ok && size_ok
                           && space_ok && strobe_ok;

        if (FIELD_W + MIN_SHIFT < ADDR_W) begin : g_narrow
            // upper address bits above the base field must be zero
        end
    end

endmodule

// File: rtl/csel_ack_fsm.sv
`timescale 1ns/1ps
module csel_ack_fsm
    import csel_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       as_n,
    input  logic                       iack,
    input  logic [NCH-1:0]             hit,
    input  logic [NCH-1:0][WAIT_W-1:0] wait_code,
    input  logic [NCH-1:0]             autovec,
    input  logic [NCH-1:0]             wide,
    output logic [1:0]                 dsack_n,
    output logic                       avec_n
);

    localparam int SEL_W = $clog2(NCH);
    localparam logic [WAIT_W-1:0] CODE_FAST = WAIT_W'((1 << WAIT_W) - 2);
    localparam logic [WAIT_W-1:0] CODE_EXT  = WAIT_W'((1 << WAIT_W) - 1);

    ack_state_t        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic              wide_q, wide_d;
    logic [SEL_W-1:0]  sel;
    logic              any_hit;
    logic [WAIT_W-1:0] sel_wait;

    // lowest index wins the acknowledge timing
    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit[i]) sel = SEL_W'(i);
        end
    end

    assign any_hit  = |hit;
    assign sel_wait = wait_code[sel];

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wide_d  = wide_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!as_n && any_hit) begin
                    wide_d = wide[sel];
                    if (iack && autovec[sel])
                        state_d = ST_AUTO;
                    else if (sel_wait == CODE_EXT)
                        state_d = ST_EXT;
                    else if (sel_wait == CODE_FAST)
                        state_d = ST_ACK;
                    else begin
                        state_d = ST_COUNT;
                        cnt_d   = sel_wait;
                    end
                end
            end
            ST_COUNT: begin
                if (as_n)
                    state_d = ST_IDLE;
                else if (cnt_q == '0)
                    state_d = ST_ACK;
                else
                    cnt_d = cnt_q - 1'b1;
            end
            ST_ACK, ST_AUTO, ST_EXT: begin
                if (as_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wide_q  <= wide_d;
        end
    end

    always_comb begin
        dsack_n = 2'b11;
        avec_n  = 1'b1;
        unique case (state_q)
            ST_ACK:  dsack_n = wide_q ? 2'b00 : 2'b10;
            ST_AUTO: avec_n  = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/csel_unit.sv
`timescale 1ns/1ps
module csel_unit
    import csel_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int CHAN_W     = 4,
    parameter int NUM_GEN    = 11,
    parameter int DISC_W     = 7,
    parameter int DISC_FIRST = 3,
    parameter int BOOT_WAIT  = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_kind,
    input  logic [CHAN_W-1:0]    wr_chan,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rnw,
    input  logic                 word_acc,
    input  logic                 iack,
    input  logic                 as_n,
    input  logic                 ds_n,
    input  logic                 aux_clk,
    output logic [NUM_GEN:0]     cs_pin_n,
    output logic [1:0]           dsack_n,
    output logic                 avec_n
);

    localparam int NCH = NUM_GEN + 1;

    logic [NCH-1:0][DATA_W-1:0] base_q;
    opt_t [NCH-1:0]             opt_q;
    logic [NCH-1:0][FUNC_W-1:0] func_q;
    logic [DISC_W-1:0]          disc_q;

    qual_t [NCH-1:0]             qual;
    logic  [NCH-1:0][WAIT_W-1:0] wait_code;
    logic  [NCH-1:0]             autovec;
    logic  [NCH-1:0]             wide;
    logic  [NCH-1:0]             cs_en;
    logic  [NCH-1:0]             hit;

    csel_regs #(
        .NCH       (NCH),
        .DATA_W    (DATA_W),
        .CHAN_W    (CHAN_W),
        .DISC_W    (DISC_W),
        .BOOT_WAIT (BOOT_WAIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_chan (wr_chan),
        .wr_data (wr_data),
        .base_q  (base_q),
        .opt_q   (opt_q),
        .func_q  (func_q),
        .disc_q  (disc_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_split
        assign qual[i].iack_sp   = opt_q[i].iack_sp;
        assign qual[i].word_only = opt_q[i].word_only;
        assign qual[i].ds_sync   = opt_q[i].ds_sync;
        assign qual[i].dir       = opt_q[i].dir;
        assign wait_code[i]      = opt_q[i].wait_code;
        assign autovec[i]        = opt_q[i].autovec;
        assign wide[i]           = func_q[i][0];
        assign cs_en[i]          = func_q[i][1];
    end

    csel_match #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W),
        .BASE_W (DATA_W)
    ) u_match (
        .base     (base_q),
        .qual     (qual),
        .cs_en    (cs_en),
        .addr     (addr),
        .rnw      (rnw),
        .word_acc (word_acc),
        .iack     (iack),
        .as_n     (as_n),
        .ds_n     (ds_n),
        .hit      (hit)
    );

    csel_ack_fsm #(
        .NCH (NCH)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .iack      (iack),
        .hit       (hit),
        .wait_code (wait_code),
        .autovec   (autovec),
        .wide      (wide),
        .dsack_n   (dsack_n),
        .avec_n    (avec_n)
    );

    // pin multiplexer: select, alternate output, or idle high
    for (genvar i = 0; i < NCH; i++) begin : g_pin
        logic alt;
        if (i >= DISC_FIRST + 1 && i < DISC_FIRST + 1 + DISC_W) begin : g_disc
            assign alt = disc_q[i-DISC_FIRST-1];
        end else if (i == DISC_FIRST + 1 + DISC_W) begin : g_clk
            assign alt = aux_clk;
        end else begin : g_high
            assign alt = 1'b1;
        end
        assign cs_pin_n[i] = func_q[i][1] ? !hit[i]
                           : ((func_q[i] == PIN_ALT) ? alt : 1'b1);
    end

endmodule

// File: rtl/csel_unit_chk.sv
`timescale 1ns/1ps
module csel_unit_chk #(
    parameter int NPIN      = 12,
    parameter int PLAIN_TOP = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            as_n,
    input logic            ds_n,
    input logic [1:0]      dsack_n,
    input logic            avec_n,
    input logic [NPIN-1:0] cs_pin_n
);

    assert_dsack_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dsack_n != 2'b01);

    assert_ack_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !avec_n |-> dsack_n == 2'b11);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(as_n) |-> (dsack_n == 2'b11 && avec_n));

    assert_idle_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n && ds_n) |-> &cs_pin_n[PLAIN_TOP:0]);

endmodule

bind csel_unit csel_unit_chk #(
    .NPIN      (NUM_GEN + 1),
    .PLAIN_TOP (DISC_FIRST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_n     (as_n),
    .ds_n     (ds_n),
    .dsack_n  (dsack_n),
    .avec_n   (avec_n),
    .cs_pin_n (cs_pin_n)
);

// File: tb/tb_csel_unit.sv
`timescale 1ns/1ps
module tb_csel_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_kind;
    logic [3:0]  wr_chan;
    logic [15:0] wr_data;
    logic [23:0] addr;
    logic        rnw, word_acc, iack, as_n, ds_n, aux_clk;
    logic [11:0] cs_pin_n;
    logic [1:0]  dsack_n;
    logic        avec_n;

    always #5 clk = ~clk;

    csel_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_chan(wr_chan), .wr_data(wr_data), .addr(addr), .rnw(rnw),
        .word_acc(word_acc), .iack(iack), .as_n(as_n), .ds_n(ds_n),
        .aux_clk(aux_clk), .cs_pin_n(cs_pin_n), .dsack_n(dsack_n),
        .avec_n(avec_n)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mbase [12];
    logic [9:0]  mopt  [12];
    logic [1:0]  mfunc [12];
    logic [6:0]  mdisc;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint szb(input logic [2:0] c);
        case (c)
            3'd0: return 2048;
            3'd1: return 8192;
            3'd2: return 16384;
            3'd3: return 65536;
            3'd4: return 131072;
            3'd5: return 262144;
            3'd6: return 524288;
            default: return 1048576;
        endcase
    endfunction

    function automatic bit mhit(int i, logic [23:0] a, bit r, bit w, bit ia,
                                bit asn, bit dsn);
        logic [9:0] o;
        longint size, lo;
        o = mopt[i];
        if (!mfunc[i][1]) return 0;
        if (o[6] ? dsn : asn) return 0;
        if (!(r ? o[4] : o[5])) return 0;
        if (o[8] && !w) return 0;
        if (o[9] != ia) return 0;
        size = szb(mbase[i][2:0]);
        lo = ((longint'(mbase[i][15:3]) * 2048) / size) * size;
        return (longint'(a) >= lo) && (longint'(a) < lo + size);
    endfunction

    function automatic logic [11:0] mpins(logic [23:0] a, bit r, bit w, bit ia,
                                          bit asn, bit dsn);
        logic [11:0] p;
        logic alt;
        for (int i = 0; i < 12; i++) begin
            if (i >= 4 && i <= 10) alt = mdisc[i-4];
            else if (i == 11)      alt = aux_clk;
            else                   alt = 1'b1;
            if (mfunc[i][1])         p[i] = !mhit(i, a, r, w, ia, asn, dsn);
            else if (mfunc[i] == 0)  p[i] = alt;
            else                     p[i] = 1'b1;
        end
        return p;
    endfunction

    task automatic wr(input logic [1:0] k, input logic [3:0] ch, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_kind = k; wr_chan = ch; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (k == 2'd3) mdisc = d[6:0];
        else if (ch < 12) begin
            case (k)
                2'd0: mbase[ch] = d;
                2'd1: mopt[ch]  = d[9:0];
                default: mfunc[ch] = d[1:0];
            endcase
        end
    endtask

    task automatic check_idle_pins(input string req);
        #1;
        chk(cs_pin_n == mpins(24'h0, 1, 1, 0, 1, 1), req, "idle pins",
            cs_pin_n, mpins(24'h0, 1, 1, 0, 1, 1));
    endtask

    // one bus cycle: pins, acknowledge kind and latency, release
    task automatic cycle(input logic [23:0] a, input bit r, input bit w,
                         input bit ia, input bit dsv, input string req);
        int sel, exp_n, got, kind;
        logic [1:0] exp_ds;
        logic [1:0] got_ds;
        logic got_av;
        logic [11:0] ep;
        sel = -1; kind = 0; exp_n = 0; exp_ds = 2'b11;
        for (int i = 11; i >= 0; i--)
            if (mhit(i, a, r, w, ia, 0, dsv)) sel = i;
        if (sel >= 0) begin
            if (ia && mopt[sel][7]) begin kind = 2; exp_n = 1; end
            else if (mopt[sel][3:0] == 15) kind = 0;
            else begin
                kind = 1;
                exp_n = (mopt[sel][3:0] == 14) ? 1 : int'(mopt[sel][3:0]) + 2;
                exp_ds = mfunc[sel][0] ? 2'b00 : 2'b10;
            end
        end
        @(negedge clk);
        addr = a; rnw = r; word_acc = w; iack = ia; as_n = 0; ds_n = dsv;
        #1;
        ep = mpins(a, r, w, ia, 0, dsv);
        chk(cs_pin_n == ep, req, $sformatf("pins @%06h", a), cs_pin_n, ep);
        got = 0; got_ds = 2'b11; got_av = 1;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (dsack_n != 2'b11 || !avec_n) begin
                got = k; got_ds = dsack_n; got_av = avec_n;
                break;
            end
        end
        if (kind == 0)
            chk(got == 0, req, $sformatf("no ack @%06h", a), got, 0);
        else begin
            chk(got == exp_n, req, $sformatf("ack latency @%06h", a), got, exp_n);
            if (kind == 2)
                chk(got_av == 0 && got_ds == 2'b11, req, "autovector", {got_av, got_ds}, 3'b011);
            else
                chk(got_ds == exp_ds && got_av == 1, req, "dsack code", got_ds, exp_ds);
        end
        as_n = 1; ds_n = 1; iack = 0;
        @(negedge clk);
        chk(dsack_n == 2'b11 && avec_n, "R9", "released", {avec_n, dsack_n}, 3'b111);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) begin
            mbase[i] = '0; mopt[i] = '0; mfunc[i] = 2'b00;
        end
        mbase[0] = 16'h0007; mopt[0] = 10'h03D; mfunc[0] = 2'b11; mdisc = 7'h7F;
        rst_n = 0; wr_en = 0; wr_kind = 0; wr_chan = 0; wr_data = 0;
        addr = 0; rnw = 1; word_acc = 1; iack = 0; as_n = 1; ds_n = 1; aux_clk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        check_idle_pins("R10");
        chk(dsack_n == 2'b11 && avec_n, "R10", "ack idle", {avec_n, dsack_n}, 3'b111);
        cycle(24'h0ABCDE, 1, 1, 0, 1, "R10");
        cycle(24'h0FFFFF, 0, 0, 0, 1, "R10");
        cycle(24'h100000, 1, 1, 0, 1, "R10");

        // R12 writes to out-of-range channels
        wr(2'd0, 4'd12, 16'hFFFF);
        wr(2'd1, 4'd13, 16'h03FF);
        wr(2'd2, 4'd15, 16'h0001);
        cycle(24'h000000, 1, 1, 0, 1, "R12");
        check_idle_pins("R12");

        // R1 size sweep on G0, base 0x300000
        wr(2'd2, 4'd1, 16'h0003);
        wr(2'd1, 4'd1, 16'h0030);
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, 4'd1, 16'h3000 | 16'(c));
            cycle(24'h300000, 1, 1, 0, 1, "R1");
            cycle(24'(32'h300000 + szb(3'(c)) - 1), 1, 1, 0, 1, "R1");
            cycle(24'(32'h300000 + szb(3'(c))), 1, 1, 0, 1, "R1");
            cycle(24'h2FFFFF, 1, 1, 0, 1, "R1");
        end
        // unaligned base rounds down
        wr(2'd0, 4'd1, 16'h3107);
        cycle(24'h300004, 1, 1, 0, 1, "R1");
        cycle(24'h3FFFF0, 1, 1, 0, 1, "R1");

        // R6 wait sweep
        wr(2'd0, 4'd1, 16'h3000);
        for (int w = 0; w < 16; w++) begin
            wr(2'd1, 4'd1, 16'h0030 | 16'(w));
            cycle(24'h300010, 1, 1, 0, 1, "R6");
        end

        // R7 8-bit port
        wr(2'd2, 4'd1, 16'h0002);
        wr(2'd1, 4'd1, 16'h0032);
        cycle(24'h300020, 1, 1, 0, 1, "R7");
        wr(2'd2, 4'd1, 16'h0003);

        // R2 / R11 overlap
        wr(2'd1, 4'd1, 16'h0039);
        wr(2'd0, 4'd2, 16'h3001);
        wr(2'd2, 4'd2, 16'h0002);
        wr(2'd1, 4'd2, 16'h0035);
        cycle(24'h300100, 1, 1, 0, 1, "R2");
        cycle(24'h301000, 1, 1, 0, 1, "R11");
        wr(2'd0, 4'd1, 16'h0000);
        wr(2'd1, 4'd1, 16'h0033);
        cycle(24'h000100, 1, 1, 0, 1, "R11");
        wr(2'd2, 4'd2, 16'h0000);

        // R4 qualifiers
        wr(2'd0, 4'd1, 16'h3000);
        wr(2'd1, 4'd1, 16'h0011);
        cycle(24'h300040, 0, 1, 0, 1, "R4");
        cycle(24'h300040, 1, 1, 0, 1, "R4");
        wr(2'd1, 4'd1, 16'h0121);
        cycle(24'h300042, 0, 0, 0, 1, "R4");
        cycle(24'h300042, 0, 1, 0, 1, "R4");
        wr(2'd1, 4'd1, 16'h0231);
        cycle(24'h300044, 1, 1, 0, 1, "R4");
        cycle(24'h300044, 1, 1, 1, 1, "R4");

        // R8 autovector
        wr(2'd1, 4'd1, 16'h02B4);
        cycle(24'h300046, 1, 1, 1, 1, "R8");
        wr(2'd1, 4'd1, 16'h00B4);
        cycle(24'h300046, 1, 1, 0, 1, "R8");

        // R5 strobe selection
        wr(2'd1, 4'd1, 16'h0072);
        cycle(24'h300048, 1, 1, 0, 1, "R5");
        cycle(24'h300048, 1, 1, 0, 0, "R5");

        // R3 pin functions
        wr(2'd3, 4'd9, 16'h0055);
        check_idle_pins("R3");
        aux_clk = 1;
        check_idle_pins("R3");
        aux_clk = 0;
        check_idle_pins("R3");
        wr(2'd2, 4'd5, 16'h0001);
        check_idle_pins("R3");
        wr(2'd0, 4'd5, 16'h3000);
        wr(2'd1, 4'd5, 16'h0030);
        wr(2'd2, 4'd5, 16'h0003);
        cycle(24'h300050, 1, 1, 0, 1, "R3");
        check_idle_pins("R3");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule